// File: doc/BRIEF.md
# Write-Permission Guard and Status Register

This block sits beside the serial command slave of a small nonvolatile byte store and answers one question for every write the slave wants to make: is it allowed? It keeps the status byte that the host reads back. That byte holds three settings that survive power cycles: a pin-lock enable and a two-bit protected-zone code. It also holds the write-enable latch and a busy flag. The nonvolatile bits are modelled as registers with a reset value.

The slave reports latch-set and latch-clear commands as single-cycle pulses. It reports each write request with its target, which is either an array address or the status register, together with the status data. It pulses a commit when the bus is released at the proper bit count. The block returns a permit flag for the pending request. An accepted commit starts a timed internal write cycle. While that cycle runs, the status byte reads all ones. When the cycle ends, the latch clears and any new status settings take effect.

An external active-low guard pin adds hardware protection. The pin matters only while the pin-lock enable bit is set. Once that bit is set and the pin is low, the status register cannot be rewritten, so the lock enable can no longer be cleared.

Top module: `wr_guard_status`

## Requirements
- R1: The status byte reads bit7 = pin-lock enable, bits 6:4 = 0, bits 3:2 = zone code, bit1 = write-enable latch, bit0 = busy. With default parameters it reads 0x00 after reset, and permit is 0.
- R2: An array write is permitted only when the target address lies outside the protected zone. Zone code 00 protects nothing; 01 protects 0xC00–0xFFF; 10 protects 0x800–0xFFF; 11 protects 0x000–0xFFF.
- R3: A status write is refused while the guard pin is low and the pin-lock enable is 1. When the pin-lock enable is 0, the pin has no effect. The pin never affects array writes.
- R4: Every write needs the latch at 1. A set pulse sets the latch and a clear pulse clears it. When both pulses arrive together, the latch clears.
- R5: A completed write cycle clears the latch. A refused commit, or a request dropped without a commit, leaves the latch and the status settings unchanged and starts no cycle.
- R6: If the guard pin goes low (with pin-lock enable 1) while a status write is pending, that write is cancelled, even if the pin returns high before the commit. A pin change after the commit has no effect.
- R7: A status write stores only data bits 7, 3 and 2. The latch and busy bits cannot be written.
- R8: An accepted commit holds busy for WR_CYCLES cycles, and the status byte reads 0xFF during that time. New status settings become visible only when the cycle ends.
- R9: While busy, write requests and latch set/clear pulses are ignored, and permit stays 0.
- R10: Permit is valid the cycle after the request is taken. It drops the cycle after select goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 1 | Bus select active (high while a transfer is open) |
| guard_n_i | input | 1 | Hardware guard pin, active low |
| latch_set_i | input | 1 | Pulse: set write-enable latch |
| latch_clr_i | input | 1 | Pulse: clear write-enable latch |
| req_vld_i | input | 1 | Pulse: a write request is presented |
| req_to_stat_i | input | 1 | Request targets the status register (1) or the array (0) |
| req_addr_i | input | ADDR_W | Array target address |
| req_data_i | input | 8 | Status data for a status write |
| commit_i | input | 1 | Pulse: bus released at a valid count, start the write |
| permit_o | output | 1 | Pending request may be written |
| status_o | output | 8 | Status byte as read back |

## Verification
The bench sweeps every combination of pin-lock enable, zone code, guard pin level and latch state. It probes zone edges (0x000, 0x7FF, 0x800, 0xBFF, 0xC00, 0xFFF) and status targets, so an off-by-one zone bound or a pin that wrongly gates array writes shows up as a wrong permit. The bench also covers two pin cases. In the first, the pin pulses low and returns high before a commit; a design without a sticky cancel would then store the new settings. In the second, the pin drops after the commit; a design that re-checked the pin would lose the write. Two further checks look at the latch. A refused commit must leave the latch set, and a latch-set pulse during the busy window must not survive the end of the cycle; a design that got either wrong would show a wrong bit 1 in the status byte afterwards.

// File: rtl/wg_pkg.sv
`timescale 1ns/1ps
package wg_pkg;

  localparam int STAT_W = 8;

  typedef enum logic [1:0] {
    ZONE_NONE    = 2'b00,
    ZONE_QUARTER = 2'b01,
    ZONE_HALF    = 2'b10,
    ZONE_ALL     = 2'b11
  } zone_e;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] zone;
  } nv_bits_t;

  // Pick the writable bits out of a status data byte (bits 7, 3, 2).
  function automatic nv_bits_t nv_from_byte(input logic [STAT_W-1:0] b);
    nv_bits_t v;
    v.lock_en = b[7];
    v.zone    = b[3:2];
    return v;
  endfunction

  function automatic logic [STAT_W-1:0] status_pack(input nv_bits_t nv,
                                                    input logic wel,
                                                    input logic busy);
    logic [STAT_W-1:0] s;
    if (busy) s = '1;
    else      s = {nv.lock_en, 3'b000, nv.zone, wel, 1'b0};
    return s;
  endfunction

endpackage

// File: rtl/wg_zone_decode.sv
`timescale 1ns/1ps
module wg_zone_decode
  import wg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        zone_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  localparam logic [ADDR_W-1:0] BOUND_QUARTER = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] BOUND_HALF    = ADDR_W'(1) << (ADDR_W - 1);

  logic [ADDR_W-1:0] bound;
  logic              any;

  // Zones are aligned to the top of the space: lower bound compare.
  always_comb begin
    any   = 1'b1;
    bound = '0;
    case (zone_e'(zone_i))
      ZONE_NONE:    any   = 1'b0;
      ZONE_QUARTER: bound = BOUND_QUARTER;
      ZONE_HALF:    bound = BOUND_HALF;
      default:      bound = '0;
    endcase
  end

  assign hit_o = any && (addr_i >= bound);

endmodule

// File: rtl/wg_cycle_timer.sv
`timescale 1ns/1ps
module wg_cycle_timer #(
  parameter int WR_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
      cnt_en = 1'b1;
    end else if (done_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/wg_status_regs.sv
`timescale 1ns/1ps
module wg_status_regs
  import wg_pkg::*;
#(
  parameter logic [2:0] NV_RST = 3'b000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wel_set_i,
  input  logic     wel_clr_i,
  input  logic     stage_i,
  input  logic     stage_is_stat_i,
  input  nv_bits_t stage_val_i,
  input  logic     done_i,
  output nv_bits_t nv_o,
  output logic     wel_o
);

  nv_bits_t nv_q, nv_d;
  nv_bits_t apply_val_q;
  logic     apply_q, apply_d;
  logic     wel_q, wel_d;
  logic     nv_en, stage_en;

  always_comb begin
    wel_d    = wel_q;
    nv_d     = nv_q;
    apply_d  = apply_q;
    nv_en    = 1'b0;
    stage_en = stage_i;
    if (wel_clr_i)      wel_d = 1'b0;
    else if (wel_set_i) wel_d = 1'b1;
    if (stage_i) apply_d = stage_is_stat_i;
    if (done_i) begin
      wel_d   = 1'b0;
      apply_d = 1'b0;
      if (apply_q) begin
        nv_d  = apply_val_q;
        nv_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q        <= nv_bits_t'(NV_RST);
      apply_val_q <= nv_bits_t'(3'b000);
      apply_q     <= 1'b0;
      wel_q       <= 1'b0;
    end else begin
      wel_q   <= wel_d;
      apply_q <= apply_d;
      if (nv_en)    nv_q        <= nv_d;
      if (stage_en) apply_val_q <= stage_val_i;
    end
  end

  assign nv_o  = nv_q;
  assign wel_o = wel_q;

endmodule

// File: rtl/wr_guard_status.sv
`timescale 1ns/1ps
module wr_guard_status
  import wg_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter int         WR_CYCLES = 8,
  parameter logic [2:0] NV_RST    = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              guard_n_i,
  input  logic              latch_set_i,
  input  logic              latch_clr_i,
  input  logic              req_vld_i,
  input  logic              req_to_stat_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [STAT_W-1:0] req_data_i,
  input  logic              commit_i,
  output logic              permit_o,
  output logic [STAT_W-1:0] status_o
);

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ok = rst_pipe_q[1];

  nv_bits_t nv;
  logic     wel, busy, done, zone_hit;
  logic     hw_lock, accept, stat_ok, permit, commit_go;

  logic              pend_q, pend_d;
  logic              pend_stat_q;
  logic              pend_kill_q, pend_kill_d;
  logic [ADDR_W-1:0] pend_addr_q;
  nv_bits_t          pend_val_q;
  logic              load_en;

  logic unused_data_bits;
  assign unused_data_bits = ^{req_data_i[6:4], req_data_i[1:0]};

  always_comb begin
    hw_lock   = nv.lock_en & ~guard_n_i;
    accept    = req_vld_i & sel_i & ~busy;
    stat_ok   = ~(hw_lock | pend_kill_q);
    permit    = pend_q & ~busy & wel & (pend_stat_q ? stat_ok : ~zone_hit);
    commit_go = commit_i & permit;
    load_en   = accept & ~commit_i;

    if (commit_i || !sel_i) pend_d = 1'b0;
    else if (accept)        pend_d = 1'b1;
    else                    pend_d = pend_q;

    if (load_en) pend_kill_d = req_to_stat_i & hw_lock;
    else         pend_kill_d = pend_kill_q | (pend_q & pend_stat_q & hw_lock);
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      pend_q      <= 1'b0;
      pend_stat_q <= 1'b0;
      pend_kill_q <= 1'b0;
      pend_addr_q <= '0;
      pend_val_q  <= nv_bits_t'(3'b000);
    end else begin
      pend_q      <= pend_d;
      pend_kill_q <= pend_kill_d;
      if (load_en) begin
        pend_stat_q <= req_to_stat_i;
        pend_addr_q <= req_addr_i;
        pend_val_q  <= nv_from_byte(req_data_i);
      end
    end
  end

  wg_zone_decode #(.ADDR_W(ADDR_W)) i_zone (
    .zone_i (nv.zone),
    .addr_i (pend_addr_q),
    .hit_o  (zone_hit)
  );

  wg_cycle_timer #(.WR_CYCLES(WR_CYCLES)) i_timer (
    .clk     (clk),
    .rst_n   (rst_ok),
    .start_i (commit_go),
    .busy_o  (busy),
    .done_o  (done)
  );

  wg_status_regs #(.NV_RST(NV_RST)) i_regs (
    .clk             (clk),
    .rst_n           (rst_ok),
    .wel_set_i       (latch_set_i & ~busy),
    .wel_clr_i       (latch_clr_i & ~busy),
    .stage_i         (commit_go),
    .stage_is_stat_i (pend_stat_q),
    .stage_val_i     (pend_val_q),
    .done_i          (done),
    .nv_o            (nv),
    .wel_o           (wel)
  );

  assign permit_o = permit;
  assign status_o = status_pack(nv, wel, busy);

endmodule

// File: rtl/wr_guard_status_chk.sv
`timescale 1ns/1ps
module wr_guard_status_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       guard_n_i,
  input logic       pend_stat,
  input logic       permit_o,
  input logic [7:0] status_o
);

  a_r1_unused_read_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    !status_o[0] |-> (status_o[6:4] == 3'b000));

  a_r3_locked_refuses_status: assert property (@(posedge clk) disable iff (!rst_ok)
    (pend_stat && !guard_n_i && status_o[7]) |-> !permit_o);

  a_r4_permit_needs_latch: assert property (@(posedge clk) disable iff (!rst_ok)
    permit_o |-> status_o[1]);

  a_r5_latch_clear_after_cycle: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(status_o[0]) |-> !status_o[1]);

  a_r8_busy_reads_all_ones: assert property (@(posedge clk) disable iff (!rst_ok)
    status_o[0] |-> (status_o == 8'hFF));

  a_r8_settings_move_only_at_end: assert property (@(posedge clk) disable iff (!rst_ok)
    (!status_o[0] && !$past(status_o[0])) |-> (status_o[7:2] == $past(status_o[7:2])));

  a_r9_no_permit_while_busy: assert property (@(posedge clk) disable iff (!rst_ok)
    status_o[0] |-> !permit_o);

endmodule

bind wr_guard_status wr_guard_status_chk i_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .guard_n_i (guard_n_i),
  .pend_stat (pend_stat_q),
  .permit_o  (permit_o),
  .status_o  (status_o)
);

// File: tb/test_wr_guard_status.sv
`timescale 1ns/1ps
module test_wr_guard_status;

  localparam int WRC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, guard_n = 1'b1, lset = 1'b0, lclr = 1'b0;
  logic        req_vld = 1'b0, req_stat = 1'b0, commit = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  data = '0;
  logic        permit;
  logic [7:0]  status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wr_guard_status #(.ADDR_W(12), .WR_CYCLES(WRC), .NV_RST(3'b000)) i_wr_guard_status (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .guard_n_i(guard_n),
    .latch_set_i(lset), .latch_clr_i(lclr), .req_vld_i(req_vld),
    .req_to_stat_i(req_stat), .req_addr_i(addr), .req_data_i(data),
    .commit_i(commit), .permit_o(permit), .status_o(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic wren(); lset = 1'b1; tick(); lset = 1'b0; endtask
  task automatic wrdi(); lclr = 1'b1; tick(); lclr = 1'b0; endtask
  task automatic req(input bit st, input logic [11:0] a, input logic [7:0] d);
    sel = 1'b1; req_vld = 1'b1; req_stat = st; addr = a; data = d;
    tick(); req_vld = 1'b0;
  endtask
  task automatic desel(); sel = 1'b0; tick(); endtask
  task automatic do_commit(); commit = 1'b1; sel = 1'b0; tick(); commit = 1'b0; endtask
  task automatic wait_idle();
    for (int n = 0; n < 100 && status[0]; n++) tick();
  endtask
  task automatic wset(input logic [7:0] d);
    wren(); req(1'b1, 12'h000, d); do_commit(); wait_idle();
  endtask

  function automatic bit zone_hit(input int z, input logic [11:0] a);
    case (z)
      0: return 1'b0;
      1: return a >= 12'hC00;
      2: return a >= 12'h800;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] probes [6];
    probes = '{12'h000, 12'h7FF, 12'h800, 12'hBFF, 12'hC00, 12'hFFF};
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk(status == 8'h00, "R1 reset status", status, 8'h00);
    chk(permit == 1'b0, "R1 reset permit", permit, 0);

    // R4 latch set / clear / both
    wren(); chk(status == 8'h02, "R4 set latch", status, 8'h02);
    wrdi(); chk(status == 8'h00, "R4 clear latch", status, 8'h00);
    wren(); lset = 1'b1; lclr = 1'b1; tick(); lset = 1'b0; lclr = 1'b0;
    chk(status == 8'h00, "R4 clear wins", status, 8'h00);

    // R2 R3 R4 sweep
    for (int w = 0; w < 2; w++) begin
      for (int z = 0; z < 4; z++) begin
        guard_n = 1'b1;
        wset({w[0], 3'b000, z[1:0], 2'b00});
        chk(status == {w[0], 3'b000, z[1:0], 2'b00}, "R7 settings stored", status,
            {w[0], 3'b000, z[1:0], 2'b00});
        for (int p = 0; p < 2; p++) begin
          for (int e = 0; e < 2; e++) begin
            guard_n = p[0];
            if (e != 0) wren(); else wrdi();
            for (int k = 0; k < 6; k++) begin
              req(1'b0, probes[k], 8'h00);
              chk(permit == (e[0] && !zone_hit(z, probes[k])), "R2 array permit",
                  permit, (e[0] && !zone_hit(z, probes[k])));
              desel();
            end
            req(1'b1, 12'h000, 8'h00);
            chk(permit == (e[0] && !(w[0] && !p[0])), "R3 status permit", permit,
                (e[0] && !(w[0] && !p[0])));
            desel();
            chk(permit == 1'b0, "R10 permit drops on deselect", permit, 0);
          end
        end
      end
    end
    guard_n = 1'b1;

    // R7 only bits 7,3,2 stored; R5 latch cleared
    wset(8'hFF);
    chk(status == 8'h8C, "R7 masked status write", status, 8'h8C);

    // R3 lock holds lock-enable; R5 refused commit keeps latch
    guard_n = 1'b0;
    wren(); req(1'b1, 12'h000, 8'h00);
    chk(permit == 1'b0, "R3 locked status permit", permit, 0);
    do_commit(); tick();
    chk(status == 8'h8E, "R5 refused commit keeps latch", status, 8'h8E);
    guard_n = 1'b1;
    wset(8'h00);
    chk(status == 8'h00, "R3 unlock with pin high", status, 8'h00);

    // R6 abort by pin pulse before commit
    wset(8'h80);
    wren(); req(1'b1, 12'h000, 8'h84);
    chk(permit == 1'b1, "R6 permit before pulse", permit, 1);
    guard_n = 1'b0; tick(); guard_n = 1'b1; tick();
    chk(permit == 1'b0, "R6 cancelled after pulse", permit, 0);
    do_commit(); tick();
    chk(status == 8'h82, "R6 cancelled write not stored", status, 8'h82);

    // R6 pin drop after commit has no effect
    req(1'b1, 12'h000, 8'h88);
    chk(permit == 1'b1, "R6 permit second try", permit, 1);
    do_commit(); guard_n = 1'b0; wait_idle(); guard_n = 1'b1;
    chk(status == 8'h88, "R6 write after commit completes", status, 8'h88);

    // R8 busy window, R9 ignored inputs
    wren(); req(1'b0, 12'h000, 8'h00);
    chk(permit == 1'b1, "R2 low half open under zone 10", permit, 1);
    do_commit();
    chk(status == 8'hFF, "R8 busy reads all ones", status, 8'hFF);
    begin
      int n;
      lset = 1'b1; sel = 1'b1; req_vld = 1'b1; req_stat = 1'b0; addr = 12'h000;
      tick(); lset = 1'b0; req_vld = 1'b0;
      n = 1;
      while (status[0] && n < 100) begin tick(); n++; end
      chk(n == WRC, "R8 busy length", n, WRC);
    end
    chk(permit == 1'b0, "R9 request during busy ignored", permit, 0);
    chk(status == 8'h88, "R9 set during busy ignored", status, 8'h88);
    desel();

    // R10 and R5: deselect without commit
    wren(); req(1'b0, 12'h000, 8'h00);
    chk(permit == 1'b1, "R10 permit next cycle", permit, 1);
    desel();
    chk(permit == 1'b0, "R10 dropped by deselect", permit, 0);
    chk(status == 8'h8A, "R5 dropped request keeps latch", status, 8'h8A);

    // R2 R5 refused array commit
    req(1'b0, 12'hC00, 8'h00);
    chk(permit == 1'b0, "R2 protected address", permit, 0);
    do_commit(); tick();
    chk(status == 8'h8A, "R5 refused array commit", status, 8'h8A);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule